// File: doc/BRIEF.md
# Alternating Two-Channel Conversion Sequencer

This block is the digital controller of a two-input converter. It runs a fixed loop. It converts, then waits with the result held, then ships the result out on a three-wire serial port, then converts again. After every finished loop it switches to the other input. There are no configuration registers. The chip-select pin alone wakes the block, aborts a transfer and restarts a conversion.

The analog conversion is replaced by a stub. The stub counts a fixed number of system clocks, then captures a 16-bit result word and a polarity flag from its inputs. The serial frame is 19 bits long: a ready flag, the channel bit, the polarity bit, and then the result with the most significant bit first.

The serial clock comes from one of two sources. It is either generated inside the block at one eighth of the system clock, or driven from outside. The level on the clock pin picks the source during power-on reset and at every falling edge of chip select. All pin inputs pass through two-flop synchronizers. Every output is registered.

Top module: `adc_pingpong_seq`

## Requirements
- R1: After reset the first frame carries channel bit 0. Each cycle that ends, whether after a full frame or by an abort, flips the channel used by the next conversion exactly once.
- R2: The loop runs in the order convert, sleep, output. When a conversion finishes the block sleeps for as long as `cs_n_i` stays high, and the captured result does not change.
- R3: If `cs_n_i` falls and then rises before any rising serial-clock edge, the block goes back to sleep. The next read returns the same result and the same channel, even if the stub inputs changed in between.
- R4: If `cs_n_i` rises after at least one rising serial-clock edge, the transfer stops. A new conversion starts on the other channel.
- R5: Frame bit order, first bit out first: ready flag (0), channel bit (0 = channel 0, 1 = channel 1), polarity bit (1 = positive), then the 16 result bits from MSB to LSB.
- R6: `sdo_o` moves to the next frame bit only after a falling serial-clock edge. `sdo_oe_o` is low whenever `cs_n_i` has been high for three clocks.
- R7: Outside the output state, while `cs_n_i` is low, `sdo_o` shows the ready flag. The flag is 1 during reset wait and during conversion, and 0 in sleep.
- R8: The 19th rising serial-clock edge ends the output state and starts a conversion. Any further clock pulses read back 1.
- R9: If the clock pin is high when `cs_n_i` falls, the block drives `sck_o` with `sck_oe_o` high during output. The period is `ISCK_DIV` clocks and there are 19 rising edges. If the pin is low, the external clock is used and `sck_oe_o` stays low.
- R10: A conversion lasts `CONV_CYCLES` system clocks, 20510 by default.
- R11: After reset the block waits `POR_CYCLES` clocks before the first conversion. During that wait `sdo_o` reads 1 under a low `cs_n_i`, and `sck_oe_o` is 0.
- R12: A rise of `cs_n_i` that lands in the same synchronized cycle as the 19th rising serial-clock edge flips the channel once and starts one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock pin level (external clock or mode strap) |
| res_word_i | input | DATA_W | Result word offered to the conversion stub |
| res_pos_i | input | 1 | Polarity flag offered to the conversion stub (1 = positive) |
| sck_o | output | 1 | Internally generated serial clock |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| sdo_o | output | 1 | Serial data / ready flag |
| sdo_oe_o | output | 1 | Drive enable for sdo_o (0 = high impedance) |

## Verification
Two events can land in the same synchronized cycle. One is chip select rising, which asks for a stop. The other is the 19th rising serial-clock edge, which finishes the frame on its own. The bench provokes this by reading 18 bits, then raising both pins in the same clock period so that both pass through the synchronizers together. The result is judged at the ports. Lowering chip select a few clocks later must show the ready flag at 1, which means a conversion is running. The following frame must carry the channel flipped exactly once, together with the data captured by that new conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_OUT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/adcseq_conv_stub.sv
module adcseq_conv_stub #(
  parameter int CONV_CYCLES = 20510,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] word_i,
  input  logic              pos_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_q,
  output logic              pos_q
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done_o = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      word_q <= '0;
      pos_q  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
    end else if (done_o) begin
      cnt    <= '0;
      word_q <= word_i;
      pos_q  <= pos_i;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3 / R2: the captured result only moves while a conversion runs
  p_hold_result_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(word_q) && $stable(pos_q)));

  // R10: a finished conversion raises a single-cycle done
  p_single_done_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/adcseq_isck.sv
module adcseq_isck #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      sck_o  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      cnt    <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      rise_o <= (cnt == CW'(HALF - 1));
      fall_o <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(HALF - 1))
        sck_o <= 1'b1;
      else if (cnt == CW'(DIV - 1))
        sck_o <= 1'b0;
    end
  end

  // R9: the generated clock only starts while enabled
  p_sck_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $past(en));
endmodule

// File: rtl/adc_pingpong_seq.sv
module adc_pingpong_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20510,
  parameter int POR_CYCLES  = 64,
  parameter int ISCK_DIV    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] res_word_i,
  input  logic              res_pos_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int RC_W    = $clog2(FRAME_W + 1);
  localparam int POR_W   = $clog2(POR_CYCLES + 1);

  seq_state_e          state;
  logic [POR_W-1:0]    por_cnt;
  logic                chan;
  logic                mode_int;
  logic [FRAME_W-1:0]  frame;
  logic [RC_W-1:0]     rise_cnt;
  logic                cs_n_s, sck_s, cs_n_d, sck_d;
  logic                cs_fall;
  logic                conv_done;
  logic [DATA_W-1:0]   data_q;
  logic                pos_q;
  logic                g_rise, g_fall;
  logic                sck_rise_x, sck_fall_x;

  adcseq_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n_i, sck_i}), .q({cs_n_s, sck_s})
  );

  adcseq_conv_stub #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_conv (
    .clk(clk), .rst(rst), .run(state == ST_CONV),
    .word_i(res_word_i), .pos_i(res_pos_i),
    .done_o(conv_done), .word_q(data_q), .pos_q(pos_q)
  );

  adcseq_isck #(.DIV(ISCK_DIV)) u_isck (
    .clk(clk), .rst(rst), .en((state == ST_OUT) && mode_int),
    .sck_o(sck_o), .rise_o(g_rise), .fall_o(g_fall)
  );

  assign cs_fall    = cs_n_d && !cs_n_s;
  assign sck_rise_x = mode_int ? g_rise : (sck_s && !sck_d);
  assign sck_fall_x = mode_int ? g_fall : (!sck_s && sck_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_d <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      sck_d  <= sck_s;
    end
  end

  // clock source: strap level during reset wait, then at each chip-select fall
  always_ff @(posedge clk) begin
    if (rst)
      mode_int <= 1'b0;
    else if (state == ST_POR || cs_fall)
      mode_int <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_POR;
      por_cnt  <= '0;
      chan     <= 1'b0;
      frame    <= '1;
      rise_cnt <= '0;
    end else begin
      unique case (state)
        ST_POR: begin
          if (por_cnt == POR_W'(POR_CYCLES - 1)) state <= ST_CONV;
          else por_cnt <= por_cnt + 1'b1;
        end
        ST_CONV: begin
          if (conv_done) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (!cs_n_s) begin
            state    <= ST_OUT;
            frame    <= {1'b0, chan, pos_q, data_q};
            rise_cnt <= '0;
          end
        end
        ST_OUT: begin
          if (cs_n_s) begin
            if (rise_cnt != '0) begin
              state <= ST_CONV;
              chan  <= !chan;
            end else begin
              state <= ST_SLEEP;
            end
          end else if (sck_rise_x) begin
            if (rise_cnt == RC_W'(FRAME_W - 1)) begin
              state <= ST_CONV;
              chan  <= !chan;
            end else begin
              rise_cnt <= rise_cnt + 1'b1;
            end
          end else if (sck_fall_x && rise_cnt != '0) begin
            frame <= {frame[FRAME_W-2:0], 1'b1};
          end
        end
        default: state <= ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o    <= 1'b1;
      sdo_oe_o <= 1'b0;
      sck_oe_o <= 1'b0;
    end else begin
      sdo_o    <= (state == ST_OUT) ? frame[FRAME_W-1] : (state != ST_SLEEP);
      sdo_oe_o <= !cs_n_s;
      sck_oe_o <= (state == ST_OUT) && mode_int;
    end
  end

  // R1: channel flips only when an output phase ends in a new conversion
  p_chan_flip_r1: assert property (@(posedge clk) disable iff (rst)
    $changed(chan) |-> ($past(state) == ST_OUT && state == ST_CONV));

  // R2: a finished conversion always lands in sleep
  p_done_to_sleep_r2: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> (state == ST_SLEEP));

  // R6: the frame advances only after a falling serial-clock edge
  p_shift_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OUT && $past(state) == ST_OUT && $changed(frame)) |-> $past(sck_fall_x));

  // R8: never more than a frame's worth of rising edges
  p_rise_bound_r8: assert property (@(posedge clk) disable iff (rst)
    rise_cnt < RC_W'(FRAME_W));

  // R7: ready flag low in sleep, high while waiting or converting
  p_flag_sleep_r7: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe_o && $past(state) == ST_SLEEP) |-> !sdo_o);
  p_flag_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_CONV || $past(state) == ST_POR) |-> sdo_o);

  // R9: the clock pin is driven only in internal-clock mode
  p_sck_drive_r9: assert property (@(posedge clk) disable iff (rst)
    sck_oe_o |-> mode_int);
endmodule

// File: tb/tb_adc_pingpong_seq.sv
module tb_adc_pingpong_seq;
  localparam int DATA_W = 16;
  localparam int CONV   = 300;
  localparam int PORC   = 32;
  localparam int DIV    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck_in = 1'b0;
  logic [DATA_W-1:0] word = 16'h1234;
  logic pos = 1'b1;
  logic sck_o, sck_oe, sdo_o, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  adc_pingpong_seq #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .POR_CYCLES(PORC), .ISCK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck_in),
    .res_word_i(word), .res_pos_i(pos),
    .sck_o(sck_o), .sck_oe_o(sck_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe)
  );

  function automatic logic [18:0] exp_frame(input logic ch, input logic p, input logic [15:0] w);
    return {1'b0, ch, p, w};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_ext(input int n, output logic [31:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      tick(10);
      bits = {bits[30:0], sdo_o};
      sck_in = 1'b1;
      tick(10);
      sck_in = 1'b0;
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (sdo_o !== 1'b0 && n < 5000) begin
      tick(1);
      n++;
    end
  endtask

  task automatic new_data(output logic [15:0] w, output logic p);
    word = 16'($urandom);
    pos  = 1'($urandom);
    w = word;
    p = pos;
  endtask

  initial begin
    logic [31:0] bits;
    logic [15:0] ew;
    logic ep, ec;
    int n;
    void'($urandom(32'd20240611));

    tick(5);
    rst = 1'b0;
    tick(2);
    chk(sdo_oe == 1'b0, "R6 reset hi-z", {31'd0, sdo_oe}, 32'd0);
    chk(sck_oe == 1'b0, "R11 reset sck drive", {31'd0, sck_oe}, 32'd0);
    cs_n = 1'b0;
    tick(6);
    chk(sdo_oe && sdo_o, "R11 flag high in reset wait", {30'd0, sdo_oe, sdo_o}, 32'd3);

    // first frame, channel 0, two extra clocks
    ew = 16'h1234; ep = 1'b1; ec = 1'b0;
    wait_ready(n);
    chk(n < 5000, "R2 first conversion completes", n, 32'd0);
    read_ext(21, bits);
    chk(bits[20:2] == exp_frame(ec, ep, ew), "R1 R5 first frame", bits[20:2], exp_frame(ec, ep, ew));
    chk(bits[1:0] == 2'b11, "R8 extra bits high", bits[1:0], 32'd3);
    ec = !ec;
    new_data(ew, ep);

    // random frames with random extra clocks
    for (int it = 0; it < 6; it++) begin
      int extra;
      extra = $urandom_range(0, 4);
      wait_ready(n);
      read_ext(19 + extra, bits);
      chk((bits >> extra) == {13'd0, exp_frame(ec, ep, ew)}, "R5 random frame", bits >> extra, exp_frame(ec, ep, ew));
      if (extra > 0)
        chk((bits & ((32'd1 << extra) - 1)) == ((32'd1 << extra) - 1), "R8 random extras", bits, (32'd1 << extra) - 1);
      ec = !ec;
      new_data(ew, ep);
    end

    // R3: peek without clocking keeps the held result
    cs_n = 1'b1;
    tick(CONV + 20);
    cs_n = 1'b0;
    tick(6);
    chk(sdo_oe && !sdo_o, "R7 flag low when result ready", {30'd0, sdo_oe, sdo_o}, 32'd2);
    cs_n = 1'b1;
    tick(6);
    chk(sdo_oe == 1'b0, "R6 hi-z after cs high", {31'd0, sdo_oe}, 32'd0);
    word = ~ew;
    pos = !ep;
    tick(4);
    cs_n = 1'b0;
    tick(6);
    read_ext(19, bits);
    chk(bits[18:0] == exp_frame(ec, ep, ew), "R3 held result and channel", bits[18:0], exp_frame(ec, ep, ew));
    ec = !ec;
    new_data(ew, ep);

    // R4: abort after first rising edge
    wait_ready(n);
    read_ext(3, bits);
    chk(bits[2:0] == exp_frame(ec, ep, ew) >> 16, "R5 partial prefix", bits[2:0], exp_frame(ec, ep, ew) >> 16);
    cs_n = 1'b1;
    ec = !ec;
    new_data(ew, ep);
    tick(3);
    cs_n = 1'b0;
    tick(6);
    n = 9;
    chk(sdo_oe && sdo_o, "R4 R7 conversion restarted", {30'd0, sdo_oe, sdo_o}, 32'd3);
    while (sdo_o !== 1'b0 && n < 5000) begin
      tick(1);
      n++;
    end
    chk(n >= CONV && n <= CONV + 10, "R10 conversion length", n, CONV + 5);
    read_ext(19, bits);
    chk(bits[18:0] == exp_frame(ec, ep, ew), "R4 frame after abort", bits[18:0], exp_frame(ec, ep, ew));
    ec = !ec;
    new_data(ew, ep);

    // R9: internal clock
    cs_n = 1'b1;
    tick(CONV + 20);
    sck_in = 1'b1;
    tick(2);
    cs_n = 1'b0;
    begin
      int k, prev_c;
      bit per_ok, oe_ok;
      logic prevs;
      k = 0; prev_c = 0; per_ok = 1'b1; oe_ok = 1'b1; prevs = 1'b0; bits = '0;
      for (int c = 0; c < 2000 && k < 19; c++) begin
        tick(1);
        if (sck_o && !prevs) begin
          bits = {bits[30:0], sdo_o};
          if (k > 0 && (c - prev_c) != DIV) per_ok = 1'b0;
          if (!sck_oe) oe_ok = 1'b0;
          prev_c = c;
          k++;
        end
        prevs = sck_o;
      end
      chk(k == 19, "R9 internal rise count", k, 32'd19);
      chk(per_ok, "R9 internal period", {31'd0, per_ok}, 32'd1);
      chk(oe_ok, "R9 sck driven", {31'd0, oe_ok}, 32'd1);
    end
    chk(bits[18:0] == exp_frame(ec, ep, ew), "R9 internal frame", bits[18:0], exp_frame(ec, ep, ew));
    tick(6);
    chk(sck_oe == 1'b0, "R9 drive released after frame", {31'd0, sck_oe}, 32'd0);
    ec = !ec;
    new_data(ew, ep);
    sck_in = 1'b0;
    cs_n = 1'b1;
    tick(4);

    // R12: chip-select rise together with the 19th rising edge
    cs_n = 1'b0;
    wait_ready(n);
    read_ext(18, bits);
    chk(bits[17:0] == exp_frame(ec, ep, ew) >> 1, "R12 first 18 bits", bits[17:0], exp_frame(ec, ep, ew) >> 1);
    tick(10);
    sck_in = 1'b1;
    cs_n = 1'b1;
    ec = !ec;
    new_data(ew, ep);
    tick(10);
    sck_in = 1'b0;
    cs_n = 1'b0;
    tick(6);
    chk(sdo_oe && sdo_o, "R12 conversion running", {30'd0, sdo_oe, sdo_o}, 32'd3);
    wait_ready(n);
    read_ext(19, bits);
    chk(bits[18:0] == exp_frame(ec, ep, ew), "R12 single channel flip", bits[18:0], exp_frame(ec, ep, ew));

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule